// File: doc/BRIEF.md
# Rejected Interrupt Resend Scanner

This block keeps a record of interrupt sources whose delivery the presenter turned away, and replays them on request. Each rejected source number sets one bit in a bank of 64-bit words, and a per-word summary bit tracks which words hold anything. When a resend command arrives, the scanner walks the marked words from the lowest to the highest. For each word it walks the marked bits from the lowest to the highest. It clears each bit and offers that source to the trigger controller as a retry, flagged as a resend.

The retry output uses a valid/ready handshake. The scanner offers at most one retry per cycle and holds the offered retry until it is accepted. Rejects may keep arriving during a scan and are never dropped. A source whose word the scan has already passed stays recorded and is replayed by the next resend. A `busy` output covers the whole scan, and resend commands that arrive while it is high have no effect.

Top module: `rej_resend_scan`

## Requirements
- R1: A pulse on `rej_valid` with source number `rej_src` records that source, and the next resend offers it as a retry. A source rejected several times before a resend is retried once.
- R2: A resend command while no source is recorded leaves `busy` low and offers no retry.
- R3: Words are visited in ascending word index, so every retry from word w precedes every retry from any word above w within one scan.
- R4: Within a word, set bits are retried in ascending bit index. Overall, the retries of one scan leave in strictly ascending source order.
- R5: The retried source number equals word index times 64 plus bit index, so it is the same number as the rejected source.
- R6: Every offered retry has `retry_resend` high.
- R7: Each source is cleared when it is retried. A second resend with no new rejects in between offers nothing and leaves `busy` low.
- R8: A reject arriving during a scan is kept. If its word lies above the word being scanned, it is retried in the same scan. If its word lies below, it is retried by the next resend.
- R9: `busy` rises the cycle after a resend command that finds a recorded source. It stays high until the last retry of the scan is accepted. Resend commands while `busy` is high do not restart the scan and cause no duplicate retries.
- R10: While `retry_valid` is high and `retry_ready` is low, the next cycle still has `retry_valid` high with the same `retry_src`. At most one retry is transferred per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rej_valid | input | 1 | A rejected source is reported this cycle |
| rej_src | input | 11 | Source number of the rejected interrupt |
| resend_cmd | input | 1 | Request to replay all recorded sources |
| busy | output | 1 | A scan is in progress |
| retry_valid | output | 1 | A retry is offered |
| retry_ready | input | 1 | The trigger controller accepts the offered retry |
| retry_src | output | 11 | Source number of the offered retry |
| retry_resend | output | 1 | Retry is issued in resend mode |

## Verification
The bench builds the block with its default 32 words of 64 bits, so the full source range from 0 to 2047 is reachable. The directed cases cover both ends of that range, the boundary between word 0 and word 1, and a completely filled word. The random rounds scatter rejects across all words and add random back-pressure, which exercises ordering across skipped empty words and the stall path. One directed case stalls a scan and injects a reject below and above the current word, together with a resend command, while the scan is in flight.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PICK = 2'd1,
    ST_WALK = 2'd2
  } scan_state_e;
endpackage

// File: rtl/rrs_lowest_set.sv
module rrs_lowest_set #(
  parameter int W = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/rrs_bitmap.sv
module rrs_bitmap #(
  parameter int WORDS = 32,
  parameter int WBITS = 64,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int BIDX_W = $clog2(WBITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [WIDX_W-1:0] set_w,
  input  logic [BIDX_W-1:0] set_b,
  input  logic              clr_bit_en,
  input  logic [WIDX_W-1:0] clr_w,
  input  logic [BIDX_W-1:0] clr_b,
  input  logic              clr_sum_en,
  input  logic [WIDX_W-1:0] clr_sum_w,
  input  logic [WIDX_W-1:0] rd_w,
  output logic [WBITS-1:0]  rd_data,
  output logic [WORDS-1:0]  sum_vec
);
  logic [WBITS-1:0] rd_arr [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WBITS-1:0] word_q;
    logic             sum_q;
    // a set in the same cycle as a clear wins, so no reject is lost
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
        sum_q  <= 1'b0;
      end else begin
        if (clr_bit_en && clr_w == WIDX_W'(w)) word_q[clr_b] <= 1'b0;
        if (clr_sum_en && clr_sum_w == WIDX_W'(w)) sum_q <= 1'b0;
        if (set_en && set_w == WIDX_W'(w)) begin
          word_q[set_b] <= 1'b1;
          sum_q         <= 1'b1;
        end
      end
    end
    assign rd_arr[w]  = word_q;
    assign sum_vec[w] = sum_q;
  end

  assign rd_data = rd_arr[rd_w];
endmodule

// File: rtl/rej_resend_scan.sv
module rej_resend_scan
  import rrs_pkg::*;
#(
  parameter int WORDS = 32,
  parameter int WBITS = 64,
  localparam int SRC_W = $clog2(WORDS) + $clog2(WBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rej_valid,
  input  logic [SRC_W-1:0] rej_src,
  input  logic             resend_cmd,
  output logic             busy,
  output logic             retry_valid,
  input  logic             retry_ready,
  output logic [SRC_W-1:0] retry_src,
  output logic             retry_resend
);
  localparam int WIDX_W = $clog2(WORDS);
  localparam int BIDX_W = $clog2(WBITS);

  function automatic logic [SRC_W-1:0] join_src(logic [WIDX_W-1:0] w, logic [BIDX_W-1:0] b);
    return SRC_W'(w) * SRC_W'(WBITS) + SRC_W'(b);
  endfunction

  function automatic logic [WIDX_W-1:0] word_of(logic [SRC_W-1:0] s);
    return WIDX_W'(s / SRC_W'(WBITS));
  endfunction

  function automatic logic [BIDX_W-1:0] bit_of(logic [SRC_W-1:0] s);
    return BIDX_W'(s % SRC_W'(WBITS));
  endfunction

  scan_state_e       state_q;
  logic [WIDX_W:0]   word_ptr_q;
  logic [WIDX_W-1:0] cur_word_q;
  logic [BIDX_W:0]   bit_ptr_q;
  logic              rv_q;
  logic [SRC_W-1:0]  rsrc_q;

  logic [WORDS-1:0]  sum_vec, sum_cand;
  logic [WBITS-1:0]  rd_data, bit_cand;
  logic              sum_found, bit_found, sum_zero, out_free;
  logic [WIDX_W-1:0] sum_idx;
  logic [BIDX_W-1:0] bit_idx;

  // named internal events
  logic ev_scan_start, ev_word_visit, ev_bit_issue, ev_word_end, ev_scan_done;

  always_comb begin
    for (int i = 0; i < WORDS; i++) sum_cand[i] = sum_vec[i] && (i >= int'(word_ptr_q));
    for (int j = 0; j < WBITS; j++) bit_cand[j] = rd_data[j] && (j >= int'(bit_ptr_q));
  end

  rrs_lowest_set #(.W(WORDS)) u_find_word (.vec(sum_cand), .found(sum_found), .idx(sum_idx));
  rrs_lowest_set #(.W(WBITS)) u_find_bit  (.vec(bit_cand), .found(bit_found), .idx(bit_idx));

  assign sum_zero      = ~|sum_vec;
  assign out_free      = !rv_q || retry_ready;
  assign ev_scan_start = state_q == ST_IDLE && resend_cmd && !sum_zero;
  assign ev_word_visit = state_q == ST_PICK && sum_found;
  assign ev_scan_done  = state_q == ST_PICK && !sum_found && out_free;
  assign ev_bit_issue  = state_q == ST_WALK && bit_found && out_free;
  assign ev_word_end   = state_q == ST_WALK && !bit_found;

  rrs_bitmap #(.WORDS(WORDS), .WBITS(WBITS)) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en     (rej_valid),
    .set_w      (word_of(rej_src)),
    .set_b      (bit_of(rej_src)),
    .clr_bit_en (ev_bit_issue),
    .clr_w      (cur_word_q),
    .clr_b      (bit_idx),
    .clr_sum_en (ev_word_visit),
    .clr_sum_w  (sum_idx),
    .rd_w       (cur_word_q),
    .rd_data    (rd_data),
    .sum_vec    (sum_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      word_ptr_q <= '0;
      cur_word_q <= '0;
      bit_ptr_q  <= '0;
      rv_q       <= 1'b0;
      rsrc_q     <= '0;
    end else begin
      if (rv_q && retry_ready) rv_q <= 1'b0;
      if (ev_scan_start) begin
        state_q    <= ST_PICK;
        word_ptr_q <= '0;
      end
      if (ev_word_visit) begin
        state_q    <= ST_WALK;
        cur_word_q <= sum_idx;
        bit_ptr_q  <= '0;
      end
      if (ev_scan_done) state_q <= ST_IDLE;
      if (ev_bit_issue) begin
        rv_q      <= 1'b1;
        rsrc_q    <= join_src(cur_word_q, bit_idx);
        bit_ptr_q <= (BIDX_W + 1)'(bit_idx) + 1'b1;
      end
      if (ev_word_end) begin
        state_q    <= ST_PICK;
        word_ptr_q <= (WIDX_W + 1)'(cur_word_q) + 1'b1;
      end
    end
  end

  assign busy         = state_q != ST_IDLE;
  assign retry_valid  = rv_q;
  assign retry_src    = rsrc_q;
  assign retry_resend = rv_q;
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
  parameter int SRC_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             resend_cmd,
  input logic             busy,
  input logic             retry_valid,
  input logic             retry_ready,
  input logic [SRC_W-1:0] retry_src,
  input logic             retry_resend,
  input logic             summary_zero,
  input logic             ev_bit_issue,
  input logic             ev_scan_done
);
  logic             have_last;
  logic [SRC_W-1:0] last_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_last <= 1'b0;
      last_src  <= '0;
    end else if (!busy) begin
      have_last <= 1'b0;
    end else if (retry_valid && retry_ready) begin
      have_last <= 1'b1;
      last_src  <= retry_src;
    end
  end

  assert_resend_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    retry_valid |-> retry_resend);

  assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    retry_valid && !retry_ready |=> retry_valid && $stable(retry_src));

  assert_empty_noop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && resend_cmd && summary_zero |=> !busy && !retry_valid);

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && resend_cmd && !summary_zero |=> busy);

  assert_retry_in_scan_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retry_valid |-> busy);

  assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    retry_valid && retry_ready && have_last |-> retry_src > last_src);

  assert_issue_in_scan_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bit_issue |-> busy && !ev_scan_done);
endmodule

bind rej_resend_scan rrs_checker #(.SRC_W(SRC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .resend_cmd   (resend_cmd),
  .busy         (busy),
  .retry_valid  (retry_valid),
  .retry_ready  (retry_ready),
  .retry_src    (retry_src),
  .retry_resend (retry_resend),
  .summary_zero (sum_zero),
  .ev_bit_issue (ev_bit_issue),
  .ev_scan_done (ev_scan_done)
);

// File: tb/rej_resend_scan_tb.sv
module rej_resend_scan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 2048;
  localparam int SW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rej_valid = 1'b0;
  logic [SW-1:0] rej_src = '0;
  logic resend_cmd = 1'b0;
  logic busy, retry_valid, retry_resend;
  logic retry_ready = 1'b0;
  logic [SW-1:0] retry_src;

  int total = 0;
  int bad = 0;
  int ready_mode = 0;
  bit model [NSRC];
  int rec [NSRC];
  int nrec = 0;
  bit hold_pending = 0;
  int hold_src = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rej_resend_scan u_dut (
    .clk(clk), .rst_n(rst_n), .rej_valid(rej_valid), .rej_src(rej_src),
    .resend_cmd(resend_cmd), .busy(busy), .retry_valid(retry_valid),
    .retry_ready(retry_ready), .retry_src(retry_src), .retry_resend(retry_resend)
  );

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected source number from word and bit, by shift instead of multiply
  function automatic int src_from(int w, int b);
    return (w << 6) | b;
  endfunction

  // retry consumer: drive ready at negedge, record transfers shortly after
  always begin
    @(negedge clk);
    case (ready_mode)
      0: retry_ready = 1'b1;
      1: retry_ready = ($urandom % 4) != 0;
      default: retry_ready = 1'b0;
    endcase
    #1;
    if (rst_n && retry_valid) begin
      check(retry_resend, "R6 resend flag", int'(retry_resend), 1);
      check(busy, "R9 busy during retry", int'(busy), 1);
      if (hold_pending)
        check(int'(retry_src) == hold_src, "R10 src held", int'(retry_src), hold_src);
      if (retry_ready) begin
        if (nrec < NSRC) rec[nrec] = int'(retry_src);
        nrec++;
        hold_pending = 0;
      end else begin
        hold_pending = 1;
        hold_src = int'(retry_src);
      end
    end else if (hold_pending) begin
      check(0, "R10 valid held", 0, 1);
      hold_pending = 0;
    end
  end

  task automatic reject(int s, bit to_model);
    @(negedge clk);
    rej_valid = 1'b1;
    rej_src = SW'(s);
    if (to_model) model[s] = 1;
    @(negedge clk);
    rej_valid = 1'b0;
  endtask

  task automatic pulse_resend();
    @(negedge clk);
    resend_cmd = 1'b1;
    @(negedge clk);
    resend_cmd = 1'b0;
  endtask

  task automatic wait_idle();
    forever begin
      @(negedge clk);
      #2;
      if (!busy) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic compare(string req);
    int k = 0;
    int n = 0;
    for (int s = 0; s < NSRC; s++) if (model[s]) n++;
    check(nrec == n, {req, " retry count"}, nrec, n);
    for (int s = 0; s < NSRC; s++) begin
      if (model[s]) begin
        if (k < nrec) check(rec[k] == s, {req, " retry order/value"}, rec[k], s);
        k++;
        model[s] = 0;
      end
    end
    nrec = 0;
  endtask

  task automatic scan(string req, bit expect_busy);
    pulse_resend();
    #2;
    check(busy == expect_busy, {req, " busy after command"}, int'(busy), int'(expect_busy));
    wait_idle();
    compare(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int s = 0; s < NSRC; s++) model[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check(!busy, "reset busy", int'(busy), 0);
    check(!retry_valid, "reset retry_valid", int'(retry_valid), 0);

    // R2: nothing recorded
    scan("R2 empty resend", 1'b0);

    // R1/R5: range ends, word boundary, duplicate reject
    reject(2047, 1); reject(0, 1); reject(63, 1); reject(64, 1);
    reject(1000, 1); reject(1000, 1);
    scan("R1 R5 directed", 1'b1);

    // R7: everything cleared
    scan("R7 second resend", 1'b0);

    // R4: a full word in scrambled order
    for (int b = 0; b < 64; b++) reject(src_from(7, (b * 37) % 64), 1);
    ready_mode = 1;
    scan("R4 full word", 1'b1);
    ready_mode = 0;

    // R10: stall holds the retry
    reject(5, 1); reject(9, 1);
    ready_mode = 2;
    pulse_resend();
    repeat (10) @(negedge clk);
    #2;
    check(retry_valid, "R10 stalled valid", int'(retry_valid), 1);
    check(int'(retry_src) == 5, "R10 stalled src", int'(retry_src), 5);
    check(nrec == 0, "R10 no transfer while stalled", nrec, 0);
    ready_mode = 0;
    wait_idle();
    compare("R10 after stall");

    // R8/R9: rejects and a resend command while a scan is stalled
    reject(200, 1); reject(300, 1);
    ready_mode = 2;
    pulse_resend();
    repeat (4) @(negedge clk);
    reject(10, 0);
    reject(2000, 1);
    pulse_resend();
    #2;
    check(busy, "R9 busy mid-scan", int'(busy), 1);
    ready_mode = 0;
    wait_idle();
    compare("R8 R9 same scan");
    model[10] = 1;
    scan("R8 passed word kept", 1'b1);

    // random rounds
    for (int r = 0; r < 8; r++) begin
      int n = 1 + int'($urandom % 40);
      int w0 = int'($urandom % 32);
      for (int i = 0; i < n; i++) begin
        if ($urandom % 2) reject(int'($urandom % NSRC), 1);
        else reject(src_from(w0, int'($urandom % 64)), 1);
      end
      ready_mode = 1;
      scan("R3 R4 random", 1'b1);
      ready_mode = 0;
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule